// File: doc/BRIEF.md
# Windowed Address Translation Table

The block rewrites bus-side addresses into link-side addresses using a small table of programmable windows. Software fills each table entry through a 32-bit register port. An entry holds a 64-bit source base, a window size that must be a power of two, a 64-bit target base and a 32-bit tag word. The tag tells the downstream logic which target space the access belongs to, for example memory, I/O, configuration or a device aperture. Windows either map to themselves or move to a different base. A typical case is an I/O aperture that lands at address zero.

For each request, every enabled entry checks whether the address falls inside its window. The lowest-numbered matching entry supplies the output. The address bits above the window size come from that entry's target base, the offset bits below it come from the request, and the entry's tag is returned with the result. If no entry matches, the block raises a miss flag, returns the address untouched and returns a zero tag. Requests and responses each use a valid/ready handshake, and the result is registered, so a response appears one cycle after its request is accepted.

Top module: `xlt_window_table`

## Requirements
- R1: After reset, every table register reads 0, so every entry is disabled, no response is pending, and any lookup misses.
- R2: Entry n is placed at register byte address n*0x20. Its words sit at these offsets: source-low at 0x00, source-high at 0x04, target-low at 0x08, target-high at 0x0C and tag at 0x10. Each of these words reads back the value last written to it. Any other offset reads 0, and a write to it changes no register.
- R3: In the source-low word, bit 0 is the enable flag. Bits [6:1] hold a size code c, and the window covers 2^(c+1) bytes. Source base bits [6:0] are taken as zero.
- R4: An enabled entry matches a request when the request address bits from position c+1 upward equal the same bits of the source base. Both the first and the last byte of a window match, and the bytes just outside it do not.
- R5: On a match, the output address is made of two parts. Bits c+1 and above come from the target base, and bits c down to 0 come from the request. The target base bits [c:0] are ignored.
- R6: On a match, rsp_tag carries the matching entry's tag word and rsp_miss is 0.
- R7: When several entries match, the entry with the lowest index supplies the address and the tag.
- R8: When no entry matches, rsp_miss is 1, rsp_addr equals the request address and rsp_tag is 0.
- R9: An entry whose enable bit is 0 never matches, whatever its other fields hold.
- R10: req_ready is high whenever no response is held or rsp_ready is high. A request accepted on one clock edge gives rsp_valid at the next clock edge.
- R11: While rsp_valid is high and rsp_ready is low, the response fields and rsp_valid hold their values. No new request is accepted during this time.
- R12: Size code 63 makes a window that covers the whole 64-bit space. Such an entry passes the request address through unchanged and returns its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register write byte address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 8 | Register read byte address |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_addr | input | 64 | Bus-side address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Translated (or unchanged) address |
| rsp_tag | output | 32 | Target-space tag of the matching entry, 0 on miss |
| rsp_miss | output | 1 | No enabled entry matched |

## Verification
The assertions check the handshake rules on every cycle. An accepted request yields a response on the next cycle. A stalled response stays frozen. A missed lookup returns exactly the address that was accepted, with a zero tag. Nothing is pending right after reset. Window arithmetic, priority between overlapping entries, disabled entries, ignored target low bits, the whole-space window and the register map depend on table contents. Only the bench's reference model shows these, through its programmed scenarios and the results it checks against on every clock.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int XLT_AW   = 64;   // translated address width
    localparam int TAG_W    = 32;   // tag word width
    localparam int SLOT_AW  = 5;    // byte address bits inside one entry
    localparam int BASE_LSB = 7;    // lowest source base bit carried in source-low

    typedef enum logic [2:0] {
        SLOT_SRC_LO,
        SLOT_SRC_HI,
        SLOT_DST_LO,
        SLOT_DST_HI,
        SLOT_TAG,
        SLOT_NONE
    } slot_e;

    typedef struct packed {
        logic              en;
        logic [5:0]        size_code;
        logic [XLT_AW-1:0] src_base;
        logic [XLT_AW-1:0] dst_base;
        logic [TAG_W-1:0]  tag;
    } xlt_entry_t;

    typedef struct packed {
        logic              miss;
        logic [XLT_AW-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } xlt_result_t;

    // Map a byte offset inside an entry to its register slot.
    function automatic slot_e decode_slot(input logic [SLOT_AW-1:0] ofs);
        case (ofs)
            5'h00:   return SLOT_SRC_LO;
            5'h04:   return SLOT_SRC_HI;
            5'h08:   return SLOT_DST_LO;
            5'h0C:   return SLOT_DST_HI;
            5'h10:   return SLOT_TAG;
            default: return SLOT_NONE;
        endcase
    endfunction

    // Offset mask of a window: bits 0..code set (window of 2^(code+1) bytes).
    function automatic logic [XLT_AW-1:0] offset_mask(input logic [5:0] code);
        logic [XLT_AW-1:0] m;
        for (int i = 0; i < XLT_AW; i++) begin
            m[i] = (i <= int'(code));
        end
        return m;
    endfunction

endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile
    import xlt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 8,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CFG_AW      = IDX_W + SLOT_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [CFG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output xlt_entry_t        entries [NUM_ENTRIES]
);

    slot_e            wslot;
    slot_e            rslot;
    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] ridx;
    logic [31:0]      ent_rd [NUM_ENTRIES];

    assign wslot = decode_slot(wr_addr[SLOT_AW-1:0]);
    assign rslot = decode_slot(rd_addr[SLOT_AW-1:0]);
    assign widx  = wr_addr[CFG_AW-1:SLOT_AW];
    assign ridx  = rd_addr[CFG_AW-1:SLOT_AW];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic [31:0] src_lo, src_hi, dst_lo, dst_hi, tag_w;
        logic        sel;

        assign sel = wr_en && (widx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                src_lo <= '0;
                src_hi <= '0;
                dst_lo <= '0;
                dst_hi <= '0;
                tag_w  <= '0;
            end else if (sel) begin
                case (wslot)
                    SLOT_SRC_LO: src_lo <= wr_data;
                    SLOT_SRC_HI: src_hi <= wr_data;
                    SLOT_DST_LO: dst_lo <= wr_data;
                    SLOT_DST_HI: dst_hi <= wr_data;
                    SLOT_TAG:    tag_w  <= wr_data;
                    default:     ;
                endcase
            end
        end

        always_comb begin
            case (rslot)
                SLOT_SRC_LO: ent_rd[e] = src_lo;
                SLOT_SRC_HI: ent_rd[e] = src_hi;
                SLOT_DST_LO: ent_rd[e] = dst_lo;
                SLOT_DST_HI: ent_rd[e] = dst_hi;
                SLOT_TAG:    ent_rd[e] = tag_w;
                default:     ent_rd[e] = '0;
            endcase
        end

        assign entries[e].en        = src_lo[0];
        assign entries[e].size_code = src_lo[6:1];
        assign entries[e].src_base  = {src_hi, src_lo[31:BASE_LSB], {BASE_LSB{1'b0}}};
        assign entries[e].dst_base  = {dst_hi, dst_lo};
        assign entries[e].tag       = tag_w;
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (ridx == IDX_W'(e)) begin
                rd_data = ent_rd[e];
            end
        end
    end

endmodule

// File: rtl/xlt_window_match.sv
module xlt_window_match
    import xlt_pkg::*;
(
    input  xlt_entry_t        entry,
    input  logic [XLT_AW-1:0] addr,
    output logic              hit,
    output logic [XLT_AW-1:0] xaddr
);

    logic [XLT_AW-1:0] keep;

    assign keep  = offset_mask(entry.size_code);
    assign hit   = entry.en && ((addr & ~keep) == (entry.src_base & ~keep));
    assign xaddr = (entry.dst_base & ~keep) | (addr & keep);

endmodule

// File: rtl/xlt_hit_pick.sv
module xlt_hit_pick
    import xlt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic              hit   [NUM_ENTRIES],
    input  logic [XLT_AW-1:0] xaddr [NUM_ENTRIES],
    input  logic [TAG_W-1:0]  tag   [NUM_ENTRIES],
    input  logic [XLT_AW-1:0] addr,
    output xlt_result_t       result
);

    // Walk from the top index down so the lowest matching index is applied last.
    always_comb begin
        result.miss = 1'b1;
        result.addr = addr;
        result.tag  = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                result.miss = 1'b0;
                result.addr = xaddr[i];
                result.tag  = tag[i];
            end
        end
    end

endmodule

// File: rtl/xlt_window_table.sv
module xlt_window_table
    import xlt_pkg::*;
#(
    parameter  int NUM_ENTRIES = 8,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CFG_AW      = IDX_W + SLOT_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic [CFG_AW-1:0] cfg_rd_addr,
    output logic [31:0]       cfg_rd_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XLT_AW-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [XLT_AW-1:0] rsp_addr,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_miss
);

    xlt_entry_t        entries [NUM_ENTRIES];
    logic              hit     [NUM_ENTRIES];
    logic [XLT_AW-1:0] xaddr   [NUM_ENTRIES];
    logic [TAG_W-1:0]  tags    [NUM_ENTRIES];
    xlt_result_t       pick;
    xlt_result_t       res_q;
    logic              valid_q;

    xlt_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .rd_addr (cfg_rd_addr),
        .rd_data (cfg_rd_data),
        .entries (entries)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
        xlt_window_match u_match (
            .entry (entries[e]),
            .addr  (req_addr),
            .hit   (hit[e]),
            .xaddr (xaddr[e])
        );
        assign tags[e] = entries[e].tag;
    end

    xlt_hit_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .hit    (hit),
        .xaddr  (xaddr),
        .tag    (tags),
        .addr   (req_addr),
        .result (pick)
    );

    assign req_ready = !valid_q || rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else if (req_valid && req_ready) begin
            valid_q <= 1'b1;
            res_q   <= pick;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_addr  = res_q.addr;
    assign rsp_tag   = res_q.tag;
    assign rsp_miss  = res_q.miss;

endmodule

// File: rtl/xlt_window_table_chk.sv
module xlt_window_table_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_addr,
    input logic [31:0] rsp_tag,
    input logic        rsp_miss
);

    // R1: nothing pending in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R10: an accepted request yields a response on the next cycle
    a_r10_accept_gives_rsp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R10: with no response held, a request is always accepted
    a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> req_ready);

    // R11: a stalled response stays frozen
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                       && $stable(rsp_tag) && $stable(rsp_miss)));

    // R8: a miss returns the accepted address with a zero tag
    a_r8_miss_passthrough: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!rsp_miss || (rsp_addr == $past(req_addr) && rsp_tag == '0)));

endmodule

bind xlt_window_table xlt_window_table_chk u_chk (.*);

// File: tb/test_xlt_window_table.sv
`timescale 1ns/1ps
module test_xlt_window_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_tag;
    logic        rsp_miss;

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;  // 50 MHz

    xlt_window_table i_xlt_window_table (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_tag(rsp_tag), .rsp_miss(rsp_miss)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_w [8][5];
    bit          m_valid = 0;
    logic [63:0] m_addr = '0;
    logic [31:0] m_tag = '0;
    bit          m_miss = 0;

    function automatic void m_lookup(input logic [63:0] a, output logic [63:0] oa,
                                     output logic [31:0] ot, output bit om);
        om = 1; oa = a; ot = '0;
        for (int e = 0; e < 8; e++) begin
            int          lg   = int'(m_w[e][0][6:1]) + 1;
            logic [63:0] keep = (lg >= 64) ? {64{1'b1}} : ((64'd1 << lg) - 64'd1);
            logic [63:0] base = {m_w[e][1], m_w[e][0][31:7], 7'b0};
            if (m_w[e][0][0] && ((a & ~keep) == (base & ~keep))) begin
                oa = ({m_w[e][3], m_w[e][2]} & ~keep) | (a & keep);
                ot = m_w[e][4];
                om = 0;
                break;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0;
            for (int e = 0; e < 8; e++)
                for (int s = 0; s < 5; s++) m_w[e][s] = '0;
        end else begin
            if (req_valid && (!m_valid || rsp_ready)) begin
                m_lookup(req_addr, m_addr, m_tag, m_miss);
                m_valid = 1;
            end else if (rsp_ready) begin
                m_valid = 0;
            end
            if (cfg_wr_en) begin
                case (cfg_wr_addr[4:0])
                    5'h00: m_w[cfg_wr_addr[7:5]][0] = cfg_wr_data;
                    5'h04: m_w[cfg_wr_addr[7:5]][1] = cfg_wr_data;
                    5'h08: m_w[cfg_wr_addr[7:5]][2] = cfg_wr_data;
                    5'h0C: m_w[cfg_wr_addr[7:5]][3] = cfg_wr_data;
                    5'h10: m_w[cfg_wr_addr[7:5]][4] = cfg_wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Compare with the model every clock, between input changes and the next edge.
    always @(posedge clk) begin
        #15;
        if (!rst && !done) begin
            chk(req_ready == (!m_valid || rsp_ready), "req_ready (R10)", 64'(req_ready), 64'(!m_valid || rsp_ready));
            chk(rsp_valid == m_valid, "rsp_valid (R10 R11)", 64'(rsp_valid), 64'(m_valid));
            if (m_valid) begin
                chk(rsp_miss == m_miss, "rsp_miss", 64'(rsp_miss), 64'(m_miss));
                chk(rsp_addr == m_addr, "rsp_addr", rsp_addr, m_addr);
                chk(rsp_tag == m_tag, "rsp_tag", 64'(rsp_tag), 64'(m_tag));
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_write(input int ent, input int ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_addr = 8'(ent * 32 + ofs); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    // R3: source-low = base low | (code << 1) | enable
    task automatic prog(input int ent, input logic [63:0] src, input int code, input bit en,
                        input logic [63:0] dst, input logic [31:0] tag);
        cfg_write(ent, 'h00, src[31:0] | 32'(code << 1) | 32'(en));
        cfg_write(ent, 'h04, src[63:32]);
        cfg_write(ent, 'h08, dst[31:0]);
        cfg_write(ent, 'h0C, dst[63:32]);
        cfg_write(ent, 'h10, tag);
    endtask

    task automatic rd_check(input int ent, input int ofs, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_addr = 8'(ent * 32 + ofs);
        #2;
        chk(cfg_rd_data == exp, "cfg_rd_data", 64'(cfg_rd_data), 64'(exp));
    endtask

    task automatic send(input logic [63:0] a);
        bit rdy;
        @(negedge clk);
        req_valid = 1; req_addr = a;
        forever begin
            #5 rdy = req_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        cur_req = "R1";
        rd_check(0, 'h00, 32'h0);
        rd_check(3, 'h10, 32'h0);
        rd_check(7, 'h0C, 32'h0);
        chk(rsp_valid == 1'b0, "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        cur_req = "R1 R8";
        send(64'h0000_0000_8000_0000);

        // Program the table
        prog(0, 64'h0000_0000_8000_0000, 19, 1, 64'h0000_0000_8000_0000, 32'h1);
        prog(1, 64'h0000_0000_5F80_0000, 22, 1, 64'h0, 32'h5);
        prog(2, 64'h0000_0040_0000_0000, 31, 1, 64'h0000_0012_0000_0000, 32'h4);
        prog(3, 64'h0000_0000_8000_0000, 27, 1, 64'h0000_0000_8000_0000, 32'h7);
        prog(4, 64'h0000_0000_1000_0000, 12, 0, 64'h0000_0000_1000_0000, 32'h9);
        prog(5, 64'h0000_0000_2000_0000, 11, 1, 64'h0000_0000_3000_0FFF, 32'h3);

        cur_req = "R2";
        rd_check(1, 'h00, 32'h5F80_0000 | (22 << 1) | 1);
        rd_check(2, 'h04, 32'h0000_0040);
        rd_check(2, 'h0C, 32'h0000_0012);
        rd_check(5, 'h08, 32'h3000_0FFF);
        rd_check(3, 'h10, 32'h7);
        cfg_write(2, 'h14, 32'hDEAD_BEEF);
        cfg_write(2, 'h06, 32'hDEAD_BEEF);
        rd_check(2, 'h14, 32'h0);
        rd_check(2, 'h00, 32'h0000_0000 | (31 << 1) | 1);
        rd_check(2, 'h08, 32'h0);
        rd_check(2, 'h10, 32'h4);

        cur_req = "R4 R6";
        send(64'h0000_0000_8000_0000);
        send(64'h0000_0000_800F_FFFF);
        cur_req = "R7";
        send(64'h0000_0000_8000_1234);
        send(64'h0000_0000_8010_0000);
        send(64'h0000_0000_8FFF_FFFF);
        cur_req = "R4 R8";
        send(64'h0000_0000_9000_0000);
        send(64'h0000_0000_7FFF_FFFF);
        cur_req = "R5";
        send(64'h0000_0000_5F80_0000);
        send(64'h0000_0000_5FFF_FFFF);
        send(64'h0000_0040_ABCD_0123);
        send(64'h0000_0000_2000_0ABC);
        cur_req = "R4 R8";
        send(64'h0000_0000_5F7F_FFFF);
        send(64'h0000_0041_0000_0000);
        cur_req = "R9";
        send(64'h0000_0000_1000_0010);

        // Back-to-back with a stalled consumer
        cur_req = "R11";
        @(negedge clk) rsp_ready = 0;
        send(64'h0000_0000_8000_0040);
        fork
            send(64'h0000_0040_0000_0008);
            begin
                repeat (4) @(negedge clk);
                rsp_ready = 1;
            end
        join
        cur_req = "R10";
        @(negedge clk);
        req_valid = 1; req_addr = 64'h0000_0000_2000_0001;
        @(negedge clk);
        req_addr = 64'h0000_0000_5F80_0010;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);

        cur_req = "R12";
        prog(7, 64'h0, 63, 1, 64'h0, 32'hA);
        send(64'h0000_0041_0000_0000);
        send(64'hFFFF_FFFF_FFFF_FFFF);
        cur_req = "R7 R12";
        send(64'h0000_0000_8000_0100);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule